// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block steers the control side of a five-stage in-order 32-bit pipeline (fetch, decode, execute, memory, writeback). Each cycle it receives the register tags of the instruction sitting in decode: two source indices, a destination index, a write enable, and flags for load and branch. It also receives the branch outcome that the datapath resolves in the execute stage. Inside, it keeps the tags of the instructions that have moved into the execute and memory output latches. It advances those tags on the same clock edge as the datapath latches, and it replaces them with bubbles whenever the pipeline is stalled or squashed.

From this state it drives the operand forwarding selects into the decode stage, one for each source operand. It raises a stall that inserts exactly one bubble when a load is followed directly by a consumer of its result. On that stall it also asks fetch to step the program counter back by one instruction. Branches are statically predicted not-taken. A taken branch resolving in execute is therefore a mispredict, and the block asks the datapath to squash fetch and decode. The register file, ALU, memories and PC arithmetic stay outside the block.

Top module: `hzc_top`

## Requirements
- R1: When the execute-stage entry is valid, writes a nonzero register equal to a decode source, and is not a load, that source's select is 01 (forward from execute).
- R2: When the execute stage does not supply a source and the memory-stage entry is valid and writes that nonzero register, the select is 10 (forward from memory). Otherwise the select is 00 (no forwarding).
- R3: When the execute and memory stages both write the register a source reads, the execute stage wins and the select is 01.
- R4: A destination of register 0, a stage with its write enable low, or an invalid decode slot never produces a nonzero select or a stall.
- R5: A valid decode instruction that reads, as rs or rt, the nonzero destination of a load in execute raises stall and pc_rewind in that same cycle, provided no mispredict is present.
- R6: A stall inserts exactly one bubble. In the following cycle the held instruction, presented again, sees no stall and gets select 10 for the load's register.
- R7: A valid branch in execute with br_taken high raises flush. With br_taken low, or with no branch in execute, flush stays low.
- R8: When a mispredict and a load-use match occur in the same cycle, flush is high and both stall and pc_rewind are low.
- R9: An instruction in decode during a flush never reaches execute. In the next cycle, a source that matches its destination gets select 00.
- R10: Synchronous active-high reset clears both tracked stages to bubbles. Right after reset, every output is 0 for any decode input.
- R11: The rs and rt selects are determined independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stage latches advance on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs | input | 5 | Decode first source register index |
| id_rt | input | 5 | Decode second source register index |
| id_rd | input | 5 | Decode destination register index |
| id_wen | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_br_taken | input | 1 | Resolved outcome of the branch in execute |
| fwd_rs | output | 2 | Select for rs: 00 none, 01 execute, 10 memory |
| fwd_rt | output | 2 | Select for rt: 00 none, 01 execute, 10 memory |
| stall | output | 1 | Hold decode and insert one bubble into execute |
| pc_rewind | output | 1 | Step fetch PC back by one instruction |
| flush | output | 1 | Squash the fetch and decode stages |

## Verification
The block's only state is the pair of tag latches for execute and memory. A corrupted entry shows up at the ports within one or two cycles, as a wrong forwarding select, a missing or doubled stall, or a flush that misfires. A bubble that is not inserted after a stall or a flush is visible one cycle later: the same decode source still matches in execute when it should match only in memory, or not at all. A tag that fails to move on to the memory stage is visible two cycles after issue, when the select for that register stays 00 instead of 10. The bench keeps its own cycle model of both latches and compares all five outputs on every cycle. This covers directed sequences for each corner and a long stretch of random tags drawn from a small register range, so that matches happen often.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    parameter int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,
        FWD_EX   = 2'b01,
        FWD_MEM  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     valid;
        reg_idx_t dst;
        logic     wen;
    } dest_tag_t;

    typedef struct packed {
        dest_tag_t d;
        logic      load;
        logic      branch;
    } ex_tag_t;

    localparam ex_tag_t   EX_BUBBLE  = '0;
    localparam dest_tag_t MEM_BUBBLE = '0;

    function automatic logic supplies(dest_tag_t t, reg_idx_t src);
        return t.valid && t.wen && (t.dst != '0) && (t.dst == src);
    endfunction

endpackage

// File: rtl/hzc_tag_pipe.sv
module hzc_tag_pipe
    import hzc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ex_tag_t   id_tag,
    input  logic      advance,
    input  logic      stall_in,
    input  logic      flush_in,
    output ex_tag_t   ex_q,
    output dest_tag_t mem_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q  <= EX_BUBBLE;
            mem_q <= MEM_BUBBLE;
        end else begin
            mem_q <= ex_q.d;
            ex_q  <= advance ? id_tag : EX_BUBBLE;
        end
    end

    // A stalled cycle must leave a bubble in execute
    assert_bubble_after_stall_R6: assert property (@(posedge clk) disable iff (rst)
        stall_in |=> !ex_q.d.valid);

    // A squashed decode instruction must not reach execute
    assert_flush_blocks_entry_R9: assert property (@(posedge clk) disable iff (rst)
        flush_in |=> !ex_q.d.valid);

    // Memory stage follows execute one cycle later
    assert_mem_follows_ex_R2: assert property (@(posedge clk) disable iff (rst)
        ex_q.d.valid |=> mem_q.valid);

endmodule

// File: rtl/hzc_fwd_unit.sv
module hzc_fwd_unit
    import hzc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      id_valid,
    input  reg_idx_t  src,
    input  dest_tag_t ex_d,
    input  logic      ex_load,
    input  dest_tag_t mem_d,
    output fwd_sel_e  sel,
    output logic      load_hit
);

    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit   = supplies(ex_d, src);
        mem_hit  = supplies(mem_d, src);
        load_hit = id_valid && ex_hit && ex_load;
        if (!id_valid)
            sel = FWD_NONE;
        else if (ex_hit && !ex_load)
            sel = FWD_EX;
        else if (mem_hit)
            sel = FWD_MEM;
        else
            sel = FWD_NONE;
    end

    assert_zero_reg_never_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == FWD_NONE));

    assert_sel_legal_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    assert_load_not_fwd_from_ex_R5: assert property (@(posedge clk) disable iff (rst)
        load_hit |-> (sel != FWD_EX));

endmodule

// File: rtl/hzc_stall_ctl.sv
module hzc_stall_ctl (
    input  logic clk,
    input  logic rst,
    input  logic id_valid,
    input  logic ex_valid,
    input  logic ex_branch,
    input  logic br_taken,
    input  logic load_use,
    output logic stall,
    output logic pc_rewind,
    output logic flush,
    output logic advance
);

    logic mispredict;

    always_comb begin
        // static prediction is not-taken, so any taken branch is a miss
        mispredict = ex_valid && ex_branch && br_taken;
        flush      = mispredict;
        stall      = load_use && !mispredict;
        pc_rewind  = stall;
        advance    = id_valid && !stall && !mispredict;
    end

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!stall && !pc_rewind));

    assert_single_bubble_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    assert_stall_holds_decode_R5: assert property (@(posedge clk) disable iff (rst)
        stall |-> !advance);

endmodule

// File: rtl/hzc_top.sv
module hzc_top
    import hzc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_wen,
    input  logic              id_load,
    input  logic              id_branch,
    input  logic              ex_br_taken,
    output logic [1:0]        fwd_rs,
    output logic [1:0]        fwd_rt,
    output logic              stall,
    output logic              pc_rewind,
    output logic              flush
);

    localparam int NSRC = 2;

    ex_tag_t   id_tag;
    ex_tag_t   ex_q;
    dest_tag_t mem_q;
    reg_idx_t  srcs     [NSRC];
    fwd_sel_e  sels     [NSRC];
    logic [NSRC-1:0] load_hits;
    logic      advance;

    always_comb begin
        id_tag.d.valid = id_valid;
        id_tag.d.dst   = id_rd;
        id_tag.d.wen   = id_wen;
        id_tag.load    = id_load;
        id_tag.branch  = id_branch;
        srcs[0]        = id_rs;
        srcs[1]        = id_rt;
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            hzc_fwd_unit u_fwd (
                .clk      (clk),
                .rst      (rst),
                .id_valid (id_valid),
                .src      (srcs[g]),
                .ex_d     (ex_q.d),
                .ex_load  (ex_q.load),
                .mem_d    (mem_q),
                .sel      (sels[g]),
                .load_hit (load_hits[g])
            );
        end
    endgenerate

    hzc_stall_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .ex_valid  (ex_q.d.valid),
        .ex_branch (ex_q.branch),
        .br_taken  (ex_br_taken),
        .load_use  (|load_hits),
        .stall     (stall),
        .pc_rewind (pc_rewind),
        .flush     (flush),
        .advance   (advance)
    );

    hzc_tag_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .id_tag   (id_tag),
        .advance  (advance),
        .stall_in (stall),
        .flush_in (flush),
        .ex_q     (ex_q),
        .mem_q    (mem_q)
    );

    assign fwd_rs = sels[0];
    assign fwd_rt = sels[1];

endmodule

// File: tb/tb_hzc_top.sv
module tb_hzc_top;

    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [4:0] id_rs = '0, id_rt = '0, id_rd = '0;
    logic       id_wen = 1'b0, id_load = 1'b0, id_branch = 1'b0;
    logic       ex_br_taken = 1'b0;
    logic [1:0] fwd_rs, fwd_rt;
    logic       stall, pc_rewind, flush;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state: one record per latched stage
    int ex_v = 0, ex_dst = 0, ex_wen = 0, ex_ld = 0, ex_br = 0;
    int mem_v = 0, mem_dst = 0, mem_wen = 0;

    always #HALF clk = ~clk;

    hzc_top dut (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
        .id_rd(id_rd), .id_wen(id_wen), .id_load(id_load), .id_branch(id_branch),
        .ex_br_taken(ex_br_taken), .fwd_rs(fwd_rs), .fwd_rt(fwd_rt),
        .stall(stall), .pc_rewind(pc_rewind), .flush(flush)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic int exp_sel(int v, int s);
        bit exh, memh;
        exh  = ex_v != 0 && ex_wen != 0 && ex_dst != 0 && ex_dst == s;
        memh = mem_v != 0 && mem_wen != 0 && mem_dst != 0 && mem_dst == s;
        if (v == 0) return 0;
        if (exh && ex_ld == 0) return 1;
        if (memh) return 2;
        return 0;
    endfunction

    // one pipeline cycle: drive, compare against model, advance model
    task automatic step(string req, int v, int rs, int rt, int rd, int wen, int ld, int br, int tk);
        int mis, lu, st;
        @(negedge clk);
        id_valid = v[0]; id_rs = rs[4:0]; id_rt = rt[4:0]; id_rd = rd[4:0];
        id_wen = wen[0]; id_load = ld[0]; id_branch = br[0]; ex_br_taken = tk[0];
        #5;
        mis = (ex_v != 0 && ex_br != 0 && tk != 0) ? 1 : 0;
        lu  = (v != 0 && ex_ld != 0 && ex_v != 0 && ex_wen != 0 && ex_dst != 0 &&
               (ex_dst == rs || ex_dst == rt)) ? 1 : 0;
        st  = (lu != 0 && mis == 0) ? 1 : 0;
        check(req, "fwd_rs", int'(fwd_rs), exp_sel(v, rs));
        check(req, "fwd_rt", int'(fwd_rt), exp_sel(v, rt));
        check(req, "stall", int'(stall), st);
        check(req, "pc_rewind", int'(pc_rewind), st);
        check(req, "flush", int'(flush), mis);
        @(posedge clk);
        mem_v = ex_v; mem_dst = ex_dst; mem_wen = ex_wen;
        if (v != 0 && st == 0 && mis == 0) begin
            ex_v = 1; ex_dst = rd; ex_wen = wen; ex_ld = ld; ex_br = br;
        end else begin
            ex_v = 0; ex_dst = 0; ex_wen = 0; ex_ld = 0; ex_br = 0;
        end
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R10: reset clears tracked stages, outputs quiet even with matching decode
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        id_valid = 1; id_rs = 5'd3; id_rt = 5'd3;
        #5;
        check("R10", "fwd_rs in reset", int'(fwd_rs), 0);
        check("R10", "stall in reset", int'(stall), 0);
        @(negedge clk);
        rst = 1'b0;
        step("R10", 1, 3, 3, 0, 0, 0, 0, 0);

        // R1: execute forward
        step("R1", 1, 0, 0, 3, 1, 0, 0, 0);
        step("R1", 1, 3, 0, 0, 0, 0, 0, 0);
        // R2: memory forward one cycle later
        step("R2", 1, 0, 3, 0, 0, 0, 0, 0);
        idle("R2");

        // R3: both stages write r5, execute wins
        step("R3", 1, 0, 0, 5, 1, 0, 0, 0);
        step("R3", 1, 0, 0, 5, 1, 0, 0, 0);
        step("R3", 1, 5, 5, 0, 0, 0, 0, 0);
        idle("R3");

        // R4: r0 destination, wen low, invalid decode
        step("R4", 1, 0, 0, 0, 1, 1, 0, 0);
        step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 0, 0, 7, 0, 0, 0, 0);
        step("R4", 1, 7, 7, 0, 0, 0, 0, 0);
        step("R4", 1, 0, 0, 8, 1, 0, 0, 0);
        step("R4", 0, 8, 8, 0, 0, 0, 0, 0);
        idle("R4");

        // R5 / R6: load-use on rs, then re-presented instruction takes memory path
        step("R5", 1, 0, 0, 9, 1, 1, 0, 0);
        step("R5", 1, 9, 0, 4, 1, 0, 0, 0);
        step("R6", 1, 9, 0, 4, 1, 0, 0, 0);
        idle("R6");
        // R5 on rt
        step("R5", 1, 0, 0, 10, 1, 1, 0, 0);
        step("R5", 1, 0, 10, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 10, 0, 0, 0, 0, 0);
        idle("R6");

        // R7: taken branch flushes, not-taken does not
        step("R7", 1, 0, 0, 0, 0, 0, 1, 0);
        step("R7", 1, 0, 0, 12, 1, 0, 0, 1);
        // R9: squashed r12 writer never appears in execute or memory
        step("R9", 1, 12, 12, 0, 0, 0, 0, 0);
        step("R9", 1, 12, 12, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 0, 0, 0, 1, 0);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 1);
        idle("R7");

        // R8: execute entry flagged as load and branch, consumer in decode, taken
        step("R8", 1, 0, 0, 6, 1, 1, 1, 0);
        step("R8", 1, 6, 0, 0, 0, 0, 0, 1);
        idle("R8");

        // R11: rs from execute while rt from memory
        step("R11", 1, 0, 0, 2, 1, 0, 0, 0);
        step("R11", 1, 0, 0, 1, 1, 0, 0, 0);
        step("R11", 1, 1, 2, 0, 0, 0, 0, 0);
        idle("R11");

        // R11: random tags over a small register range, all outputs compared
        for (int i = 0; i < 400; i++) begin
            step("R11", ($urandom % 4) != 0, $urandom % 4, $urandom % 4, $urandom % 4,
                 $urandom % 2, ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom % 2);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule